// File: doc/BRIEF.md
# Receiver Fault Flag and Interrupt Controller

This block watches the health monitors of a twelve-channel optical receiver and reports faults to a host. Sampled readings arrive as 8-bit values: die temperature, two supply rails (A and B), and an optical power level for each channel. The block compares each reading with a programmable upper and lower limit. It also takes a loss-of-signal input for each channel. Each fault sets its own flag bit. A flag is sticky: it stays set until the host reads the byte that holds it.

Each flag has a mask bit. The unmasked flags are ORed together to drive an active-low interrupt line. A control bit selects the interrupt style. In level style the line stays low while any unmasked flag is set. In pulse style the line drops for a fixed number of cycles each time that OR goes from low to high. The host reaches flags, masks, limits and the control bit through a plain byte-wide register port. The port has a write strobe and a read strobe, and read data arrives one cycle after the read strobe.

Top module: `alarm_ctrl`

## Requirements
- R1: A monitor reading strictly greater than its upper limit sets the upper flag of that monitor. A reading equal to the limit sets nothing. Flag bits: temperature upper = bit 36, rail A upper = 38, rail B upper = 40, channel n power upper = 12+n.
- R2: A monitor reading strictly less than its lower limit sets the lower flag of that monitor. A reading equal to the limit sets nothing. Flag bits: temperature lower = 37, rail A lower = 39, rail B lower = 41, channel n power lower = 24+n.
- R3: A high level on loss-of-signal input n sets flag bit n (n = 0..11) and no other flag.
- R4: Once set, a flag stays set after its cause goes away, until a host read clears it.
- R5: A read strobe at flag address k (0..5) returns flag bits 8k+7..8k as they were before the read. Those bits are cleared at the same edge, and no other flag byte changes.
- R6: A flag whose cause is still present at the clearing read is set again at that edge, so the next read of the byte still shows it.
- R7: When a flag's cause appears in the same cycle that a read clears its byte, the flag ends up set. That read returns the value from before the edge.
- R8: A flag whose mask bit is 1 does not drive the interrupt, but it still latches and reads back. Mask bit i covers flag bit i, and mask byte k sits at address 0x08+k.
- R9: In level style (control bit 0 = 0), the interrupt output is low whenever at least one unmasked flag is set. It returns high once the reads have cleared all unmasked flags.
- R10: In pulse style (control bit 0 = 1), the interrupt output goes low for exactly 4 cycles after the OR of the unmasked flags rises. It does not pulse again while that OR stays high.
- R11: Reset clears all flags and all masks. It sets every upper limit to 0xFF, every lower limit to 0x00 and the control bit to level style, and the interrupt output sits high.
- R12: The limit registers sit at 0x10+2m (upper) and 0x11+2m (lower), for m = temperature 0, rail A 1, rail B 2, optical power 3. The power limits are shared by all channels. Control is at 0x18. Reading any address other than 0x00..0x05 returns the register value and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| temp_mon | input | 8 | Temperature reading |
| rail_a_mon | input | 8 | Supply rail A reading |
| rail_b_mon | input | 8 | Supply rail B reading |
| pwr_mon | input | 96 | Optical power readings, channel n in bits 8n+7..8n |
| los_in | input | 12 | Loss-of-signal per channel |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench drives readings exactly equal to the limits and one step past them. A comparator written as greater-or-equal, or with the limits swapped, shows up as a wrong flag byte. It holds a fault while reading its byte, and raises a fault in the same cycle as the read. A design that gives priority to the clear would lose that fault, and the next read would show the missing bit. It reads one flag byte and then its neighbour, to catch a clear decode that touches the wrong byte. In pulse style it counts the low cycles after a rising OR. It then adds a second fault while the OR is still high, where a design that retriggers on any new flag would pulse a second time.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int DW   = 8;   // register and monitor width
    localparam int AW   = 5;   // register address width
    localparam int NENV = 6;   // upper/lower flags of temperature and two rails
    localparam int NMON = 4;   // limit pairs: temperature, rail A, rail B, power

    // address group in wr_addr/rd_addr[4:3]
    localparam logic [1:0] RG_FLAG = 2'd0;
    localparam logic [1:0] RG_MASK = 2'd1;
    localparam logic [1:0] RG_LIM  = 2'd2;
    localparam logic [1:0] RG_CTRL = 2'd3;

    typedef enum logic [1:0] {
        MON_TEMP = 2'd0,
        MON_RA   = 2'd1,
        MON_RB   = 2'd2,
        MON_PWR  = 2'd3
    } mon_e;

    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } limit_t;

    typedef struct packed {
        logic over;
        logic under;
    } excur_t;

    function automatic excur_t check_limits(input logic [DW-1:0] v, input limit_t l);
        excur_t r;
        r.over  = (v > l.hi);
        r.under = (v < l.lo);
        return r;
    endfunction

    function automatic int flag_bits(input int nch);
        return 3 * nch + NENV;
    endfunction

    function automatic int flag_bytes(input int nch);
        return (flag_bits(nch) + DW - 1) / DW;
    endfunction

endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
    import alarm_pkg::*;
#(
    parameter int NBYTE = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    output logic [NBYTE*DW-1:0]   mask_o,
    output limit_t [NMON-1:0]     lim_o,
    output irq_mode_e             mode_o
);

    logic [1:0] grp;
    logic [2:0] sel;

    assign grp = wr_addr[AW-1:AW-2];
    assign sel = wr_addr[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '0;
            for (int m = 0; m < NMON; m++) begin
                lim_o[m].hi <= '1;
                lim_o[m].lo <= '0;
            end
            mode_o <= IRQ_LEVEL;
        end else if (wr_en) begin
            if (grp == RG_MASK) begin
                for (int b = 0; b < NBYTE; b++) begin
                    if (sel == 3'(b)) mask_o[b*DW +: DW] <= wr_data;
                end
            end
            if (grp == RG_LIM) begin
                for (int m = 0; m < NMON; m++) begin
                    if (sel[2:1] == 2'(m)) begin
                        if (sel[0]) lim_o[m].lo <= wr_data;
                        else        lim_o[m].hi <= wr_data;
                    end
                end
            end
            if (grp == RG_CTRL && sel == 3'd0) begin
                mode_o <= irq_mode_e'(wr_data[0]);
            end
        end
    end

endmodule

// File: rtl/alarm_cond.sv
module alarm_cond
    import alarm_pkg::*;
#(
    parameter int NCH = 12,
    parameter int FW  = 48
) (
    input  logic [DW-1:0]      temp_i,
    input  logic [DW-1:0]      rail_a_i,
    input  logic [DW-1:0]      rail_b_i,
    input  logic [NCH*DW-1:0]  pwr_i,
    input  logic [NCH-1:0]     los_i,
    input  limit_t [NMON-1:0]  lim_i,
    output logic [FW-1:0]      cond_o
);

    localparam int NFLAG   = flag_bits(NCH);
    localparam int ENV_LSB = 3 * NCH;

    logic [DW-1:0] env_val [3];

    assign env_val[0] = temp_i;
    assign env_val[1] = rail_a_i;
    assign env_val[2] = rail_b_i;

    // per-channel loss of signal and optical power excursions
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        excur_t ex;
        assign ex = check_limits(pwr_i[ch*DW +: DW], lim_i[int'(MON_PWR)]);
        assign cond_o[ch]           = los_i[ch];
        assign cond_o[NCH + ch]     = ex.over;
        assign cond_o[2*NCH + ch]   = ex.under;
    end

    // temperature and supply rails, one limit pair each
    for (genvar m = 0; m < 3; m++) begin : g_env
        excur_t ex;
        assign ex = check_limits(env_val[m], lim_i[m]);
        assign cond_o[ENV_LSB + 2*m]     = ex.over;
        assign cond_o[ENV_LSB + 2*m + 1] = ex.under;
    end

    if (FW > NFLAG) begin : g_pad
        assign cond_o[FW-1:NFLAG] = '0;
    end

endmodule

// File: rtl/alarm_flags.sv
module alarm_flags
    import alarm_pkg::*;
#(
    parameter int NBYTE = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NBYTE*DW-1:0]  cond_i,
    input  logic                 rd_en,
    input  logic [AW-1:0]        rd_addr,
    output logic [NBYTE*DW-1:0]  flags_o,
    output logic [NBYTE*DW-1:0]  clr_o
);

    always_comb begin
        clr_o = '0;
        if (rd_en && rd_addr[AW-1:AW-2] == RG_FLAG) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (rd_addr[2:0] == 3'(b)) clr_o[b*DW +: DW] = '1;
            end
        end
    end

    // a new event outranks the clear of the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~clr_o) | cond_i;
    end

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
    import alarm_pkg::*;
#(
    parameter int W         = 48,
    parameter int PULSE_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  flags_i,
    input  logic [W-1:0]  mask_i,
    input  irq_mode_e     mode_i,
    output logic          irq_n_o
);

    localparam int CW = $clog2(PULSE_LEN + 1);

    logic          any_w;
    logic          any_q;
    logic [CW-1:0] cnt_q;

    assign any_w = |(flags_i & ~mask_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            any_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            any_q <= any_w;
            if (any_w && !any_q)  cnt_q <= CW'(PULSE_LEN);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        if (mode_i == IRQ_PULSE) irq_n_o = (cnt_q == '0);
        else                     irq_n_o = !any_w;
    end

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
    import alarm_pkg::*;
#(
    parameter int NCH       = 12,
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic [DW-1:0]       temp_mon,
    input  logic [DW-1:0]       rail_a_mon,
    input  logic [DW-1:0]       rail_b_mon,
    input  logic [NCH*DW-1:0]   pwr_mon,
    input  logic [NCH-1:0]      los_in,
    output logic                irq_n
);

    localparam int NBYTE = flag_bytes(NCH);
    localparam int FW    = NBYTE * DW;

    logic [FW-1:0]      mask_w;
    logic [FW-1:0]      cond_w;
    logic [FW-1:0]      flags_w;
    logic [FW-1:0]      clr_w;
    limit_t [NMON-1:0]  lim_w;
    irq_mode_e          mode_w;
    logic [DW-1:0]      rd_mux;

    alarm_cfg_regs #(.NBYTE(NBYTE)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask_o  (mask_w),
        .lim_o   (lim_w),
        .mode_o  (mode_w)
    );

    alarm_cond #(.NCH(NCH), .FW(FW)) u_cond (
        .temp_i   (temp_mon),
        .rail_a_i (rail_a_mon),
        .rail_b_i (rail_b_mon),
        .pwr_i    (pwr_mon),
        .los_i    (los_in),
        .lim_i    (lim_w),
        .cond_o   (cond_w)
    );

    alarm_flags #(.NBYTE(NBYTE)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cond_w),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .flags_o (flags_w),
        .clr_o   (clr_w)
    );

    alarm_irq #(.W(FW), .PULSE_LEN(PULSE_LEN)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags_w),
        .mask_i  (mask_w),
        .mode_i  (mode_w),
        .irq_n_o (irq_n)
    );

    always_comb begin
        rd_mux = '0;
        case (rd_addr[AW-1:AW-2])
            RG_FLAG: begin
                for (int b = 0; b < NBYTE; b++)
                    if (rd_addr[2:0] == 3'(b)) rd_mux = flags_w[b*DW +: DW];
            end
            RG_MASK: begin
                for (int b = 0; b < NBYTE; b++)
                    if (rd_addr[2:0] == 3'(b)) rd_mux = mask_w[b*DW +: DW];
            end
            RG_LIM: begin
                for (int m = 0; m < NMON; m++)
                    if (rd_addr[2:1] == 2'(m))
                        rd_mux = rd_addr[0] ? lim_w[m].lo : lim_w[m].hi;
            end
            RG_CTRL: begin
                if (rd_addr[2:0] == 3'd0) rd_mux = {{(DW-1){1'b0}}, mode_w == IRQ_PULSE};
            end
            default: rd_mux = '0;
        endcase
    end

    // read data holds the pre-clear flag byte captured at the strobe edge
    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

endmodule

// File: rtl/alarm_ctrl_chk.sv
module alarm_ctrl_chk
    import alarm_pkg::*;
#(
    parameter int W         = 48,
    parameter int PULSE_LEN = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  flags,
    input logic [W-1:0]  clr,
    input logic [W-1:0]  cond,
    input logic [W-1:0]  mask,
    input irq_mode_e     mode,
    input logic          irq_n
);

    logic [15:0] low_run;
    logic [15:0] pulse_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            pulse_run <= '0;
        end else begin
            if (irq_n)                low_run <= '0;
            else if (low_run != '1)   low_run <= low_run + 1'b1;
            if (mode != IRQ_PULSE)    pulse_run <= '0;
            else if (pulse_run != '1) pulse_run <= pulse_run + 1'b1;
        end
    end

    // R4: a set flag that was not cleared is still set one cycle later
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~clr)) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

    // R7: every active cause is latched at the next edge, clear or not
    p_cond_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (|cond) |=> ((flags & $past(cond)) == $past(cond)));

    // R5: cleared bits without a live cause are zero after the read edge
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (|clr) |=> ((flags & $past(clr & ~cond)) == '0));

    // R9: in level style a low output needs an unmasked flag
    p_level_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_LEVEL && !irq_n) |-> (|(flags & ~mask)));

    // R10: in settled pulse style each low stretch lasts the full length
    p_pulse_len_r10: assert property (@(posedge clk) disable iff (rst)
        (pulse_run >= 16'(PULSE_LEN + 2) && $rose(irq_n)) |-> (low_run >= 16'(PULSE_LEN)));

endmodule

bind alarm_ctrl alarm_ctrl_chk #(.W(FW), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .flags (flags_w),
    .clr   (clr_w),
    .cond  (cond_w),
    .mask  (mask_w),
    .mode  (mode_w),
    .irq_n (irq_n)
);

// File: tb/tb_alarm_ctrl.sv
module tb_alarm_ctrl;

    localparam int NCH = 12;
    localparam int FW  = 48;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              rd_en = 1'b0;
    logic [4:0]        rd_addr = '0;
    logic [7:0]        rd_data;
    logic [7:0]        temp_mon = '0;
    logic [7:0]        rail_a_mon = '0;
    logic [7:0]        rail_b_mon = '0;
    logic [NCH*8-1:0]  pwr_mon = '0;
    logic [NCH-1:0]    los_in = '0;
    logic              irq_n;

    always #4 clk = ~clk;

    alarm_ctrl #(.NCH(NCH), .PULSE_LEN(4)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .temp_mon(temp_mon), .rail_a_mon(rail_a_mon), .rail_b_mon(rail_b_mon),
        .pwr_mon(pwr_mon), .los_in(los_in), .irq_n(irq_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [FW-1:0] m_flags = '0;
    logic [FW-1:0] m_mask  = '0;
    logic [7:0]    m_lim [8];
    logic          m_mode  = 1'b0;

    task automatic model_reset();
        m_flags = '0;
        m_mask  = '0;
        for (int i = 0; i < 8; i++) m_lim[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
        m_mode  = 1'b0;
    endtask

    function automatic logic [FW-1:0] cond_calc();
        logic [FW-1:0] c = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            c[ch]          = los_in[ch];
            c[NCH + ch]    = pwr_mon[ch*8 +: 8] > m_lim[6];
            c[2*NCH + ch]  = pwr_mon[ch*8 +: 8] < m_lim[7];
        end
        c[36] = temp_mon > m_lim[0];
        c[37] = temp_mon < m_lim[1];
        c[38] = rail_a_mon > m_lim[2];
        c[39] = rail_a_mon < m_lim[3];
        c[40] = rail_b_mon > m_lim[4];
        c[41] = rail_b_mon < m_lim[5];
        return c;
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (a[4:3])
            2'd0: return (a[2:0] < 3'd6) ? m_flags[8*a[2:0] +: 8] : 8'h00;
            2'd1: return (a[2:0] < 3'd6) ? m_mask[8*a[2:0] +: 8] : 8'h00;
            2'd2: return m_lim[a[2:0]];
            default: return (a == 5'd24) ? {7'd0, m_mode} : 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: inputs already set at a falling edge
    task automatic step(input bit do_rd, input logic [4:0] a, input bit chk, input string req);
        logic [FW-1:0] c;
        logic [FW-1:0] clr;
        logic [7:0]    e;
        rd_en   = do_rd;
        rd_addr = a;
        c   = cond_calc();
        e   = exp_read(a);
        clr = (do_rd && a < 5'd6) ? (48'hFF << (8 * a)) : '0;
        @(posedge clk);
        @(negedge clk);
        m_flags = (m_flags & ~clr) | c;
        rd_en   = 1'b0;
        if (do_rd && chk) check(rd_data == e, req, 32'(rd_data), 32'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 5'd0, 1'b0, "");
    endtask

    task automatic rd_expect(input logic [4:0] a, input logic [7:0] exp, input string req);
        step(1'b1, a, 1'b0, req);
        check(rd_data == exp, req, 32'(rd_data), 32'(exp));
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        logic [FW-1:0] c;
        c = cond_calc();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_flags = m_flags | c;
        if (a[4:3] == 2'd1 && a[2:0] < 3'd6) m_mask[8*a[2:0] +: 8] = d;
        if (a[4:3] == 2'd2) m_lim[a[2:0]] = d;
        if (a == 5'd24) m_mode = d[0];
    endtask

    task automatic chk_level(input string req);
        logic e;
        e = !(|(m_flags & ~m_mask));
        check(irq_n == e, req, 32'(irq_n), 32'(e));
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            idle(1);
            if (!irq_n) lows++;
        end
    endtask

    task automatic clear_all();
        for (int b = 0; b < 6; b++) step(1'b1, 5'(b), 1'b1, "R5 flag byte drain");
    endtask

    task automatic nominal();
        temp_mon = 8'h50; rail_a_mon = 8'h80; rail_b_mon = 8'h80;
        for (int ch = 0; ch < NCH; ch++) pwr_mon[ch*8 +: 8] = 8'h80;
        los_in = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int lows;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset defaults
        check(irq_n == 1'b1, "R11 irq idle after reset", 32'(irq_n), 32'd1);
        rd_expect(5'd2,  8'h00, "R11 flags clear");
        rd_expect(5'd8,  8'h00, "R11 mask clear");
        rd_expect(5'd22, 8'hFF, "R11 upper limit default");
        rd_expect(5'd23, 8'h00, "R11 lower limit default");
        rd_expect(5'd24, 8'h00, "R11 level style default");

        // program limits
        wr(5'h10, 8'h80); wr(5'h11, 8'h20);
        wr(5'h12, 8'hB0); wr(5'h13, 8'h50);
        wr(5'h14, 8'hB0); wr(5'h15, 8'h50);
        wr(5'h16, 8'hC0); wr(5'h17, 8'h40);
        nominal();
        idle(1);
        clear_all();

        // R1 strict upper compare and R4 stickiness
        temp_mon = 8'h80; idle(1);
        rd_expect(5'd4, 8'h00, "R1 equal to upper limit");
        temp_mon = 8'h81; idle(1);
        temp_mon = 8'h50; idle(1);
        rd_expect(5'd4, 8'h10, "R1 R4 over limit latched");
        rd_expect(5'd4, 8'h00, "R5 byte cleared by read");

        // R2 strict lower compare
        temp_mon = 8'h20; idle(1);
        rd_expect(5'd4, 8'h00, "R2 equal to lower limit");
        temp_mon = 8'h1F; idle(1);
        temp_mon = 8'h50;
        rd_expect(5'd4, 8'h20, "R2 under limit latched");
        rail_b_mon = 8'h4F; idle(1); rail_b_mon = 8'h80;
        rd_expect(5'd5, 8'h02, "R2 rail B lower");

        // R3 loss of signal
        los_in[11] = 1'b1; idle(1); los_in = '0;
        rd_expect(5'd0, 8'h00, "R3 other channels untouched");
        rd_expect(5'd1, 8'h08, "R3 channel 11 flag");

        // R5 clear isolation
        pwr_mon[7:0] = 8'hD0; los_in[0] = 1'b1; idle(1);
        los_in = '0; pwr_mon[7:0] = 8'h80;
        rd_expect(5'd0, 8'h01, "R5 pre-clear value");
        rd_expect(5'd0, 8'h00, "R5 cleared");
        rd_expect(5'd1, 8'h10, "R5 neighbour byte kept");

        // R6 cause persists across read
        los_in[5] = 1'b1; idle(1);
        rd_expect(5'd0, 8'h20, "R6 first read");
        rd_expect(5'd0, 8'h20, "R6 re-set while present");
        los_in = '0; idle(1);
        rd_expect(5'd0, 8'h20, "R6 held after cause gone");
        rd_expect(5'd0, 8'h00, "R6 finally clear");

        // R7 set wins over clear in the same cycle
        los_in[6] = 1'b1;
        rd_expect(5'd0, 8'h00, "R7 read returns pre-edge value");
        los_in = '0;
        rd_expect(5'd0, 8'h40, "R7 event kept");

        // R8 masked flag
        wr(5'h08, 8'h01);
        los_in[0] = 1'b1; idle(1); los_in = '0; idle(1);
        check(irq_n == 1'b1, "R8 masked flag no interrupt", 32'(irq_n), 32'd1);
        rd_expect(5'd0, 8'h01, "R8 masked flag still latched");
        wr(5'h08, 8'h00);

        // R9 level style
        los_in[1] = 1'b1; idle(1); los_in = '0;
        check(irq_n == 1'b0, "R9 level asserted", 32'(irq_n), 32'd0);
        idle(3);
        check(irq_n == 1'b0, "R9 level held", 32'(irq_n), 32'd0);
        rd_expect(5'd0, 8'h02, "R9 flag read");
        check(irq_n == 1'b1, "R9 level released", 32'(irq_n), 32'd1);

        // R10 pulse style
        wr(5'h18, 8'h01);
        los_in[2] = 1'b1; idle(1); los_in = '0;
        count_low(10, lows);
        check(lows == 4, "R10 pulse length", 32'(lows), 32'd4);
        los_in[3] = 1'b1; idle(1); los_in = '0;
        count_low(10, lows);
        check(lows == 0, "R10 no pulse while OR high", 32'(lows), 32'd0);
        rd_expect(5'd0, 8'h0C, "R10 flags held");
        idle(2);
        los_in[4] = 1'b1; idle(1); los_in = '0;
        count_low(10, lows);
        check(lows == 4, "R10 second pulse after clear", 32'(lows), 32'd4);
        rd_expect(5'd0, 8'h10, "R10 flag read");
        wr(5'h18, 8'h00);

        // R12 non-flag reads leave flags alone
        los_in[7] = 1'b1; idle(1); los_in = '0;
        rd_expect(5'h10, 8'h80, "R12 upper limit readback");
        rd_expect(5'h08, 8'h00, "R12 mask readback");
        rd_expect(5'h18, 8'h00, "R12 control readback");
        rd_expect(5'h0E, 8'h00, "R12 unused address");
        rd_expect(5'd0, 8'h80, "R12 flag kept after other reads");

        // random phase, level style
        for (int it = 0; it < 400; it++) begin
            logic [4:0] a;
            temp_mon   = 8'($urandom);
            rail_a_mon = 8'($urandom);
            rail_b_mon = 8'($urandom);
            for (int ch = 0; ch < NCH; ch++) pwr_mon[ch*8 +: 8] = 8'(32'h30 + $urandom % 160);
            los_in = 12'($urandom & $urandom & $urandom);
            if ($urandom % 20 == 0) begin
                wr(5'(8 + $urandom % 6), 8'($urandom));
            end else begin
                a = ($urandom % 4 == 0) ? 5'(8 + $urandom % 17) : 5'($urandom % 6);
                step($urandom % 2 == 0, a, 1'b1, "R5 R1 R2 R3 random read");
            end
            chk_level("R9 R8 random level interrupt");
        end

        // R11 reset after use
        nominal();
        wr(5'h09, 8'hFF);
        wr(5'h18, 8'h01);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        model_reset();
        rd_expect(5'd9,  8'h00, "R11 mask restored");
        rd_expect(5'd24, 8'h00, "R11 control restored");
        rd_expect(5'h10, 8'hFF, "R11 limit restored");
        check(irq_n == 1'b1, "R11 irq high after reset", 32'(irq_n), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule